// File: doc/BRIEF.md
# Bus Performance Monitoring Counter Unit

This unit watches two strobes from a bus: a read-data beat strobe and a write-data beat strobe. It counts them in four event counters and also runs a cycle counter beside them, so software can divide the event count by the cycle count to get a load figure. Software drives the unit through a 32-bit register port with word addresses. A request is one cycle of `bus_valid`, and read data is registered on the clock edge that takes the request.

Two run states gate all counting. In `ST_STOPPED` the counters are frozen. In `ST_COUNTING` a counter advances when its own enable bit is set. Writing 1 to control bit 0 takes the GO transition into `ST_COUNTING`. Writing 0 to control bit 0 takes the HALT transition back to `ST_STOPPED`, so software halts the unit and then reads a consistent snapshot. Separate set and clear registers switch the enable bits. Pulse bits in the control register zero the event counters or the cycle counter. Event counter 3 is 40 bits wide and is read as a low word and a high word.

Top module: `bpm_unit`

## Requirements
- R1: After reset, all counters, enable bits and event selects are zero, the unit is in `ST_STOPPED`, and every register reads 0.
- R2: A write to the enable-set register (0x04) turns on each enable whose bit is 1; bits that are 0 have no effect. In the enable map, bit 31 is the cycle counter and bits 3:0 are event counters 3..0.
- R3: A write to the enable-clear register (0x08) turns off each enable whose bit is 1. Reading either 0x04 or 0x08 returns the enable map.
- R4: A counter advances only in `ST_COUNTING` and only while its own enable bit is 1. Otherwise it holds its value through any beat activity.
- R5: Writing the control register (0x00) with bit 1 set zeroes all event counters, and with bit 2 set zeroes the cycle counter. The same write may set bit 0. Bits 1 and 2 read back as 0.
- R6: The 2-bit select at 0x30 + 4*i chooses the events counted by event counter i. 0 counts nothing, 1 counts read beats, 2 counts write beats, and 3 counts both, adding 2 when both strobes are high in one cycle. The select reads back its stored value.
- R7: The cycle counter (0x0C) and event counters 0..2 (0x10, 0x14, 0x18) read as 32-bit values. Event counter 3 reads bits 31:0 at 0x1C and bits 39:32 at 0x20 in bits 7:0, with the upper bits zero.
- R8: A read of an unmapped address returns 0. Read data is valid right after the clock edge that takes the request.
- R9: The GO transition (control write with bit 0 = 1) enters `ST_COUNTING`, and the HALT transition (control write with bit 0 = 0) enters `ST_STOPPED`. Control bit 0 reads back the current state. The cycle counter counts every edge after GO, up to and including the HALT edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rd_beat | input | 1 | One read-data beat this cycle |
| wr_beat | input | 1 | One write-data beat this cycle |

## Verification
A wrong run state or enable bit does not show until the counters are read after the next HALT. It then appears as a count that is too high, too low or unchanged. The bench therefore works out the exact edge count for every GO..HALT window and compares each counter against it. A select decoded wrongly shows as a mixed-up read/write total in the same read-back. A frozen counter that drifts is caught by repeating the reads after beats that arrive while halted.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    localparam int NUM_EVT = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    typedef enum logic [0:0] {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_EN_SET = 8'h04;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 8'h08;
    localparam logic [ADDR_W-1:0] A_CYCLE  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_EVT0   = 8'h10;
    localparam logic [ADDR_W-1:0] A_EVT3HI = 8'h20;
    localparam logic [ADDR_W-1:0] A_SEL0   = 8'h30;

    localparam int CTL_RUN     = 0;
    localparam int CTL_EVT_CLR = 1;
    localparam int CTL_CYC_CLR = 2;
    localparam int MAP_CYC_BIT = 31;
endpackage

// File: rtl/bpm_counter.sv
module bpm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step_en,
    input  logic [1:0]   step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (step_en) cnt <= cnt + W'(step);
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !clr) |=> $stable(cnt)); // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R5
endmodule

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
    import bpm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_ctrl,
    input  logic                    wr_set,
    input  logic                    wr_clr,
    input  logic [NUM_EVT-1:0]      wr_sel,
    input  logic [2:0]              ctl_bits,
    input  logic [NUM_EVT:0]        map_bits,
    input  logic [1:0]              sel_bits,
    output logic                    run,
    output logic                    clr_evt,
    output logic                    clr_cyc,
    output logic [NUM_EVT:0]        en_map,
    output logic [NUM_EVT-1:0][1:0] sel
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (wr_ctrl &&  ctl_bits[CTL_RUN]) state_d = ST_COUNTING;
            ST_COUNTING: if (wr_ctrl && !ctl_bits[CTL_RUN]) state_d = ST_STOPPED;
            default:     state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        run     = (state_q == ST_COUNTING);
        clr_evt = wr_ctrl && ctl_bits[CTL_EVT_CLR];
        clr_cyc = wr_ctrl && ctl_bits[CTL_CYC_CLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_map <= '0;
        else if (wr_set) en_map <= en_map | map_bits;
        else if (wr_clr) en_map <= en_map & ~map_bits;
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sel[i] <= 2'b00;
            else if (wr_sel[i]) sel[i] <= sel_bits;
        end
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_map & $past(map_bits)) == $past(map_bits))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en_map & $past(map_bits)) == '0)); // R3
    AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (run == $past(ctl_bits[CTL_RUN]))); // R9
endmodule

// File: rtl/bpm_unit.sv
module bpm_unit
    import bpm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int HI_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);
    localparam int WIDE_W = CNT_W + HI_W;

    logic                    wr_req, rd_req;
    logic                    wr_ctrl, wr_set, wr_clr;
    logic [NUM_EVT-1:0]      wr_sel;
    logic                    run, clr_evt, clr_cyc;
    logic [NUM_EVT:0]        en_map;
    logic [NUM_EVT-1:0][1:0] sel;
    logic [CNT_W-1:0]        cyc_cnt;
    logic [CNT_W-1:0]        evt_lo [NUM_EVT];
    logic [HI_W-1:0]         evt_hi;
    logic [DATA_W-1:0]       rd_mux;
    logic                    addr_hit;
    logic [DATA_W-1:0]       map_word;

    assign wr_req  = bus_valid &&  bus_write;
    assign rd_req  = bus_valid && !bus_write;
    assign wr_ctrl = wr_req && (bus_addr == A_CTRL);
    assign wr_set  = wr_req && (bus_addr == A_EN_SET);
    assign wr_clr  = wr_req && (bus_addr == A_EN_CLR);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_wsel
        assign wr_sel[i] = wr_req && (bus_addr == A_SEL0 + ADDR_W'(4 * i));
    end

    bpm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr),
        .wr_sel   (wr_sel),
        .ctl_bits (bus_wdata[2:0]),
        .map_bits ({bus_wdata[MAP_CYC_BIT], bus_wdata[NUM_EVT-1:0]}),
        .sel_bits (bus_wdata[1:0]),
        .run      (run),
        .clr_evt  (clr_evt),
        .clr_cyc  (clr_cyc),
        .en_map   (en_map),
        .sel      (sel)
    );

    bpm_counter #(.W(CNT_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_cyc),
        .step_en (run && en_map[NUM_EVT]),
        .step    (2'd1),
        .cnt     (cyc_cnt)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic [1:0] step;
        assign step = {1'b0, sel[i][0] & rd_beat} + {1'b0, sel[i][1] & wr_beat};
        if (i == NUM_EVT - 1) begin : g_wide
            logic [WIDE_W-1:0] cnt;
            bpm_counter #(.W(WIDE_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr_evt),
                .step_en (run && en_map[i]),
                .step    (step),
                .cnt     (cnt)
            );
            assign evt_lo[i] = cnt[CNT_W-1:0];
            assign evt_hi    = cnt[WIDE_W-1:CNT_W];
        end else begin : g_narrow
            bpm_counter #(.W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr_evt),
                .step_en (run && en_map[i]),
                .step    (step),
                .cnt     (evt_lo[i])
            );
        end
    end

    always_comb begin
        map_word                 = '0;
        map_word[MAP_CYC_BIT]    = en_map[NUM_EVT];
        map_word[NUM_EVT-1:0]    = en_map[NUM_EVT-1:0];
        rd_mux   = '0;
        addr_hit = 1'b1;
        if (bus_addr == A_CTRL)                       rd_mux = DATA_W'(run);
        else if (bus_addr == A_EN_SET ||
                 bus_addr == A_EN_CLR)                rd_mux = map_word;
        else if (bus_addr == A_CYCLE)                 rd_mux = DATA_W'(cyc_cnt);
        else if (bus_addr == A_EVT3HI)                rd_mux = DATA_W'(evt_hi);
        else begin
            addr_hit = 1'b0;
            for (int i = 0; i < NUM_EVT; i++) begin
                if (bus_addr == A_EVT0 + ADDR_W'(4 * i)) begin
                    rd_mux   = DATA_W'(evt_lo[i]);
                    addr_hit = 1'b1;
                end
                if (bus_addr == A_SEL0 + ADDR_W'(4 * i)) begin
                    rd_mux   = DATA_W'(sel[i]);
                    addr_hit = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !addr_hit) |=> (bus_rdata == '0)); // R8
endmodule

// File: tb/tb_bpm_unit.sv
module tb_bpm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bpm_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_beat(rd_beat), .wr_beat(wr_beat)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic beat(input logic r, input logic w);
        @(negedge clk);
        rd_beat = r; wr_beat = w;
        @(posedge clk);
        #1 rd_beat = 1'b0; wr_beat = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic expect_counts(input string req, input logic [31:0] cyc,
                                 input logic [31:0] e0, input logic [31:0] e1,
                                 input logic [31:0] e2, input logic [31:0] e3);
        expect_reg(req, 8'h0C, cyc);
        expect_reg(req, 8'h10, e0);
        expect_reg(req, 8'h14, e1);
        expect_reg(req, 8'h18, e2);
        expect_reg(req, 8'h1C, e3);
        expect_reg({req, " R7 hi"}, 8'h20, 32'h0);
    endtask

    task automatic t_reset_state();
        chk("R1 rdata", bus_rdata, 32'h0);
        expect_reg("R1 ctrl", 8'h00, 32'h0);
        expect_reg("R1 enmap", 8'h04, 32'h0);
        for (int i = 0; i < 4; i++) expect_reg("R1 sel", 8'h30 + 8'(4 * i), 32'h0);
        expect_counts("R1 counters", 0, 0, 0, 0, 0);
    endtask

    task automatic t_enable_regs();
        bus_wr(8'h04, 32'h8000_0005);
        expect_reg("R2 set", 8'h04, 32'h8000_0005);
        bus_wr(8'h04, 32'h0);
        expect_reg("R2 zero write", 8'h04, 32'h8000_0005);
        bus_wr(8'h04, 32'h0000_000A);
        expect_reg("R2 set more", 8'h04, 32'h8000_000F);
        bus_wr(8'h08, 32'h8000_0001);
        expect_reg("R3 clear", 8'h08, 32'h0000_000E);
        expect_reg("R3 map via set addr", 8'h04, 32'h0000_000E);
        bus_wr(8'h04, 32'h8000_0001);
        expect_reg("R2 restore", 8'h08, 32'h8000_000F);
    endtask

    task automatic t_selects();
        bus_wr(8'h30, 32'h1);
        bus_wr(8'h34, 32'h2);
        bus_wr(8'h38, 32'h3);
        bus_wr(8'h3C, 32'h3);
        expect_reg("R6 sel0", 8'h30, 32'h1);
        expect_reg("R6 sel1", 8'h34, 32'h2);
        expect_reg("R6 sel2", 8'h38, 32'h3);
        expect_reg("R6 sel3", 8'h3C, 32'h3);
    endtask

    task automatic t_counting();
        // GO with both reset pulses; 9 beat edges, then HALT edge: 10 cycles
        bus_wr(8'h00, 32'h7);
        for (int i = 0; i < 3; i++) beat(1'b1, 1'b0);
        for (int i = 0; i < 2; i++) beat(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) beat(1'b1, 1'b1);
        bus_wr(8'h00, 32'h0);
        expect_counts("R6 R9 counting", 10, 7, 6, 13, 13);
    endtask

    task automatic t_freeze();
        for (int i = 0; i < 5; i++) beat(1'b1, 1'b1);
        expect_counts("R4 frozen", 10, 7, 6, 13, 13);
    endtask

    task automatic t_resets();
        bus_wr(8'h00, 32'h2);
        expect_counts("R5 event reset", 10, 0, 0, 0, 0);
        bus_wr(8'h00, 32'h4);
        expect_counts("R5 cycle reset", 0, 0, 0, 0, 0);
        bus_wr(8'h00, 32'h7);
        expect_reg("R5 R9 ctrl readback", 8'h00, 32'h1);
        bus_wr(8'h00, 32'h0);
        expect_reg("R9 halted readback", 8'h00, 32'h0);
        // GO edge, read edge, HALT edge: 2 counted edges
        expect_reg("R9 cycle window", 8'h0C, 32'd2);
    endtask

    task automatic t_gating();
        bus_wr(8'h00, 32'h6);
        bus_wr(8'h08, 32'h2);
        bus_wr(8'h3C, 32'h0);
        bus_wr(8'h00, 32'h1);
        beat(1'b1, 1'b1);
        beat(1'b1, 1'b1);
        bus_wr(8'h00, 32'h0);
        expect_counts("R4 R6 gating", 3, 2, 0, 4, 0);
    endtask

    task automatic t_unmapped();
        expect_reg("R8 unmapped 0x24", 8'h24, 32'h0);
        expect_reg("R8 unmapped 0xFC", 8'hFC, 32'h0);
        expect_reg("R8 after unmapped", 8'h04, 32'h8000_000D);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_enable_regs();
        t_selects();
        t_counting();
        t_freeze();
        t_resets();
        t_gating();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule